// File: doc/BRIEF.md
# Multicycle Instruction Cycle Sequencer

This block is the control and datapath core of a small register processor that runs each instruction as a fixed series of steps. It reads an instruction word from memory into an instruction register. It then moves the instruction pointer on by one in a step of its own, and decodes the opcode. A memory operand is fetched only for the one opcode that needs it. Execution and write-back come last, and then the cycle starts again at the fetch step. Instructions never overlap: instruction i+1 is not fetched until instruction i has finished its execute step.

The block has a single synchronous memory port, shared by instruction reads, operand reads and stores. The memory may take any number of cycles to answer, so every memory step waits on a ready input. The current step is driven out as a phase code, which lets the surrounding logic or a bench follow the exact step order for each opcode.

Instruction word (default 8 bits): opcode in bits [7:6], register field A in bits [5:4], operand field in bits [3:0]. For a register add, the second register index is bits [1:0].

Top module: `cycle_seq`

## Requirements
- R1: A synchronous reset places the sequencer in the fetch phase, sets the instruction pointer to 0 and clears all registers to 0. The first fetch after reset reads address 0.
- R2: `phase` carries the step code: fetch=0, advance=1, decode=2, operand=3, execute=4. Steps run fetch, advance, decode, then operand (only when needed), then execute, then fetch again.
- R3: In fetch, the block raises `memRd` with `memAddr` equal to the instruction pointer, and on ready it loads `memRdata` into the instruction register.
- R4: The advance step takes exactly one cycle and adds one to the instruction pointer before decode begins.
- R5: Only opcode 01 (load) visits the operand step. For opcodes 00, 10 and 11, decode goes straight to execute.
- R6: Opcode 00 (add) writes A+B, modulo 2^DW, into register A. Execute makes no memory access for this opcode.
- R7: Opcode 01 (load) reads memory at the zero-extended operand field during the operand step, and writes that data into register A in execute.
- R8: Opcode 10 (store) raises `memWr` in execute with `memAddr` equal to the zero-extended operand field and `memWdata` equal to register A.
- R9: Opcode 11 (jump) replaces the already-advanced pointer with the zero-extended operand field in execute. The next fetch reads from that address.
- R10: While a memory request is raised and `memReady` is low, the phase and `memAddr` stay unchanged. `memRd` and `memWr` are never high together.
- R11: After execute completes, the next phase is always fetch. A store completes only when ready is seen, and the other opcodes complete in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | AW | Memory address |
| memRd | output | 1 | Read request |
| memWr | output | 1 | Write request |
| memWdata | output | DW | Store data |
| memRdata | input | DW | Read data, valid when ready |
| memReady | input | 1 | Memory completes the current request |
| phase | output | 3 | Current step code |

## Verification
Two events can land in the same cycle: the memory completes a request, and the sequencer leaves its phase and raises the next request. This happens when a store finishes and the following fetch begins with `memReady` still high. The bench provokes it with a zero-latency memory, which holds ready high across back-to-back store and fetch requests. A second run uses latencies of one to three cycles that rotate per access, to exercise the hold behaviour. In both runs, an independent instruction model predicts the order of phase entries and of completed accesses, including the address and the store data. The bench judges each completed access and each phase change against that prediction.

// File: rtl/cycle_seq_pkg.sv
package cycle_seq_pkg;

  typedef enum logic [2:0] {
    PH_FETCH   = 3'd0,
    PH_ADVANCE = 3'd1,
    PH_DECODE  = 3'd2,
    PH_OPERAND = 3'd3,
    PH_EXECUTE = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    OP_ADD   = 2'b00,
    OP_LOAD  = 2'b01,
    OP_STORE = 2'b10,
    OP_JUMP  = 2'b11
  } opcode_e;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic irLoad;      // capture read data into the instruction register
    logic ipInc;       // advance the instruction pointer
    logic ipJump;      // overwrite the pointer with the operand field
    logic mdrLoad;     // capture operand data
    logic regWe;       // write register A
    logic regSrcMem;   // write-back source: operand data instead of adder
    logic addrOperand; // address the operand field instead of the pointer
    logic memRd;
    logic memWr;
  } strobe_t;

endpackage

// File: rtl/cycle_seq_ctrl.sv
module cycle_seq_ctrl
  import cycle_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  opcode_e irOp,
  input  logic    memReady,
  output phase_e  phase,
  output strobe_t strobe
);

  phase_e  state;
  phase_e  nextState;
  opcode_e decOp;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PH_FETCH;
      decOp <= OP_ADD;
    end else begin
      state <= nextState;
      if (state == PH_DECODE) decOp <= irOp;
    end
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      PH_FETCH: begin
        strobe.memRd = 1'b1;
        if (memReady) begin
          strobe.irLoad = 1'b1;
          nextState     = PH_ADVANCE;
        end
      end
      PH_ADVANCE: begin
        strobe.ipInc = 1'b1;
        nextState    = PH_DECODE;
      end
      PH_DECODE: begin
        nextState = (irOp == OP_LOAD) ? PH_OPERAND : PH_EXECUTE;
      end
      PH_OPERAND: begin
        strobe.memRd       = 1'b1;
        strobe.addrOperand = 1'b1;
        if (memReady) begin
          strobe.mdrLoad = 1'b1;
          nextState      = PH_EXECUTE;
        end
      end
      PH_EXECUTE: begin
        unique case (decOp)
          OP_ADD: begin
            strobe.regWe = 1'b1;
            nextState    = PH_FETCH;
          end
          OP_LOAD: begin
            strobe.regWe     = 1'b1;
            strobe.regSrcMem = 1'b1;
            nextState        = PH_FETCH;
          end
          OP_STORE: begin
            strobe.memWr       = 1'b1;
            strobe.addrOperand = 1'b1;
            if (memReady) nextState = PH_FETCH;
          end
          OP_JUMP: begin
            strobe.ipJump = 1'b1;
            nextState     = PH_FETCH;
          end
          default: nextState = PH_FETCH;
        endcase
      end
      default: nextState = PH_FETCH;
    endcase
  end

  assign phase = state;

endmodule

// File: rtl/cycle_seq_dp.sv
module cycle_seq_dp
  import cycle_seq_pkg::*;
#(
  parameter int DW   = 8,
  parameter int AW   = 8,
  parameter int NREG = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  strobe_t                       strobe,
  input  logic [DW-1:0]                 memRdata,
  output logic [AW-1:0]                 memAddr,
  output logic [DW-1:0]                 memWdata,
  output opcode_e                       irOp,
  output logic [DW-3-$clog2(NREG):0]    irImm,
  output logic [AW-1:0]                 instrPtr
);

  localparam int RIW  = $clog2(NREG);
  localparam int IMMW = DW - 2 - RIW;

  logic [AW-1:0]   ip;
  logic [DW-1:0]   ir;
  logic [DW-1:0]   mdr;
  logic [DW-1:0]   regFile [NREG];
  logic [RIW-1:0]  raIdx;
  logic [RIW-1:0]  rbIdx;
  logic [IMMW-1:0] imm;
  logic [DW-1:0]   aluSum;
  logic [DW-1:0]   wrData;

  assign raIdx = ir[DW-3 -: RIW];
  assign imm   = ir[IMMW-1:0];
  assign rbIdx = imm[RIW-1:0];

  assign aluSum = regFile[raIdx] + regFile[rbIdx];
  assign wrData = strobe.regSrcMem ? mdr : aluSum;

  always_ff @(posedge clk) begin
    if (rst) begin
      ip  <= '0;
      ir  <= '0;
      mdr <= '0;
    end else begin
      if (strobe.irLoad)  ir  <= memRdata;
      if (strobe.mdrLoad) mdr <= memRdata;
      if (strobe.ipJump)     ip <= AW'(imm);
      else if (strobe.ipInc) ip <= ip + AW'(1);
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : gReg
    always_ff @(posedge clk) begin
      if (rst) regFile[g] <= '0;
      else if (strobe.regWe && raIdx == RIW'(g)) regFile[g] <= wrData;
    end
  end

  assign memAddr  = strobe.addrOperand ? AW'(imm) : ip;
  assign memWdata = regFile[raIdx];
  assign irOp     = opcode_e'(ir[DW-1 -: 2]);
  assign irImm    = imm;
  assign instrPtr = ip;

endmodule

// File: rtl/cycle_seq.sv
module cycle_seq
  import cycle_seq_pkg::*;
#(
  parameter int DW   = 8,
  parameter int AW   = 8,
  parameter int NREG = 4
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] memAddr,
  output logic          memRd,
  output logic          memWr,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata,
  input  logic          memReady,
  output logic [2:0]    phase
);

  localparam int IMMW = DW - 2 - $clog2(NREG);

  strobe_t         strobe;
  phase_e          curPhase;
  opcode_e         irOp;
  logic [IMMW-1:0] irImm;
  logic [AW-1:0]   instrPtr;

  cycle_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .irOp     (irOp),
    .memReady (memReady),
    .phase    (curPhase),
    .strobe   (strobe)
  );

  cycle_seq_dp #(.DW(DW), .AW(AW), .NREG(NREG)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .irOp     (irOp),
    .irImm    (irImm),
    .instrPtr (instrPtr)
  );

  assign memRd = strobe.memRd;
  assign memWr = strobe.memWr;
  assign phase = curPhase;

endmodule

module cycle_seq_chk
  import cycle_seq_pkg::*;
#(
  parameter int AW   = 8,
  parameter int IMMW = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      phase,
  input logic            memRd,
  input logic            memWr,
  input logic            memReady,
  input logic [AW-1:0]   memAddr,
  input logic [AW-1:0]   instrPtr,
  input opcode_e         irOp,
  input logic [IMMW-1:0] irImm
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (phase == 3'(PH_FETCH) && instrPtr == '0));

  a_r2_after_fetch: assert property (@(posedge clk) disable iff (rst)
    phase == 3'(PH_FETCH) |=> (phase == 3'(PH_FETCH) || phase == 3'(PH_ADVANCE)));

  a_r4_advance_once: assert property (@(posedge clk) disable iff (rst)
    phase == 3'(PH_ADVANCE) |=> (phase == 3'(PH_DECODE) && instrPtr == $past(instrPtr) + AW'(1)));

  a_r5_skip_operand: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'(PH_DECODE) && irOp != OP_LOAD) |=> phase == 3'(PH_EXECUTE));

  a_r5_operand_only_load: assert property (@(posedge clk) disable iff (rst)
    phase == 3'(PH_OPERAND) |-> irOp == OP_LOAD);

  a_r9_jump_target: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'(PH_EXECUTE) && irOp == OP_JUMP) |=> instrPtr == AW'($past(irImm)));

  a_r10_hold_wait: assert property (@(posedge clk) disable iff (rst)
    ((memRd || memWr) && !memReady) |=> ($stable(phase) && $stable(memAddr)));

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(memRd && memWr));

  a_r11_back_to_fetch: assert property (@(posedge clk) disable iff (rst)
    phase == 3'(PH_EXECUTE) |=> (phase == 3'(PH_EXECUTE) || phase == 3'(PH_FETCH)));

endmodule

bind cycle_seq cycle_seq_chk #(.AW(AW), .IMMW(IMMW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .phase    (phase),
  .memRd    (memRd),
  .memWr    (memWr),
  .memReady (memReady),
  .memAddr  (memAddr),
  .instrPtr (instrPtr),
  .irOp     (irOp),
  .irImm    (irImm)
);

// File: tb/sim_cycle_seq.sv
module sim_cycle_seq;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] memAddr;
  logic       memRd;
  logic       memWr;
  logic [7:0] memWdata;
  logic [7:0] memRdata;
  logic       memReady = 1'b0;
  logic [2:0] phase;

  always #(CLK_PERIOD/2) clk = ~clk;

  cycle_seq u0 (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
    .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady), .phase(phase)
  );

  logic [7:0] mem [256];
  logic [7:0] img [16];
  assign memRdata = mem[memAddr];

  int total = 0;
  int bad = 0;
  int lat = 0;
  int waitCnt = 0;
  int accNum = 0;
  bit varLat = 1'b0;

  // Scoreboard queues
  logic [2:0]  expPh[$];
  string       expPhTag[$];
  logic [16:0] expAcc[$];   // {write, addr, data}
  string       expAccTag[$];
  logic [2:0]  lastPhase = 3'd7;
  logic [2:0]  ePh;
  logic [16:0] eAcc;
  string       eTag;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // Memory model: writes land at the accepting edge
  always @(posedge clk) begin
    if (!rst && memWr && memReady) mem[memAddr] <= memWdata;
  end

  // Ready generator, updated a quarter period after each rising edge (R10 waits)
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (memReady) begin
      accNum++;
      lat = varLat ? (accNum % 3) + 1 : 0;
    end
    if (rst || !(memRd || memWr)) begin
      waitCnt  = 0;
      memReady = 1'b0;
    end else if (memReady) begin
      waitCnt  = 0;
      memReady = (lat == 0);
    end else if (waitCnt >= lat) begin
      memReady = 1'b1;
    end else begin
      waitCnt++;
    end
  end

  // Monitor: phase entries and completed accesses
  always @(negedge clk) begin
    if (rst) begin
      lastPhase = 3'd7;
    end else begin
      if (phase != lastPhase) begin
        if (expPh.size() > 0) begin
          ePh  = expPh.pop_front();
          eTag = expPhTag.pop_front();
          check(phase == ePh, eTag, "phase entry", int'(phase), int'(ePh));
        end
        lastPhase = phase;
      end
      if ((memRd || memWr) && memReady && expAcc.size() > 0) begin
        eAcc = expAcc.pop_front();
        eTag = expAccTag.pop_front();
        check(memWr == eAcc[16], eTag, "access kind", int'(memWr), int'(eAcc[16]));
        check(memAddr == eAcc[15:8], eTag, "access addr", int'(memAddr), int'(eAcc[15:8]));
        if (eAcc[16])
          check(memWdata == eAcc[7:0], eTag, "store data", int'(memWdata), int'(eAcc[7:0]));
      end
    end
  end

  task automatic pushPh(input logic [2:0] p, input string t);
    expPh.push_back(p);
    expPhTag.push_back(t);
  endtask

  task automatic pushAcc(input bit w, input logic [7:0] a, input logic [7:0] d, input string t);
    expAcc.push_back({w, a, d});
    expAccTag.push_back(varLat ? {t, " R10"} : t);
  endtask

  // Instruction-level model built from the requirements
  task automatic buildModel(input int n);
    logic [7:0] m [256];
    logic [7:0] r [4];
    logic [7:0] ip = 8'd0;
    bit afterJump = 1'b0;
    for (int i = 0; i < 256; i++) m[i] = mem[i];
    for (int i = 0; i < 4; i++) r[i] = 8'd0;        // R1 cleared registers
    for (int k = 0; k < n; k++) begin
      logic [7:0] ins;
      logic [1:0] op, ra, rb;
      logic [3:0] imm;
      pushPh(3'd0, "R11");
      pushAcc(1'b0, ip, 8'd0, afterJump ? "R9" : "R3");
      ins = m[ip];
      op = ins[7:6]; ra = ins[5:4]; imm = ins[3:0]; rb = ins[1:0];
      pushPh(3'd1, "R4");
      ip = ip + 8'd1;
      pushPh(3'd2, "R2");
      afterJump = 1'b0;
      case (op)
        2'b01: begin
          pushPh(3'd3, "R5");
          pushAcc(1'b0, {4'd0, imm}, 8'd0, "R7");
          pushPh(3'd4, "R7");
          r[ra] = m[{4'd0, imm}];
        end
        2'b00: begin
          pushPh(3'd4, "R5");
          r[ra] = r[ra] + r[rb];                  // R6
        end
        2'b10: begin
          pushPh(3'd4, "R5");
          pushAcc(1'b1, {4'd0, imm}, r[ra], "R6 R8");
          m[{4'd0, imm}] = r[ra];
        end
        default: begin
          pushPh(3'd4, "R5");
          ip = {4'd0, imm};                        // R9
          afterJump = 1'b1;
        end
      endcase
    end
  endtask

  task automatic runProgram(input int n);
    int guard;
    @(posedge clk);
    #1 rst = 1'b1;
    expPh.delete(); expPhTag.delete(); expAcc.delete(); expAccTag.delete();
    accNum = 0;
    lat = varLat ? 1 : 0;
    for (int i = 0; i < 256; i++) mem[i] = (i < 16) ? img[i] : 8'd0;
    buildModel(n);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(phase == 3'd0, "R1", "reset phase", int'(phase), 0);
    check(memAddr == 8'd0, "R1", "first fetch addr", int'(memAddr), 0);
    check(memRd == 1'b1 && memWr == 1'b0, "R3", "fetch read strobe", int'({memRd, memWr}), 2);
    guard = 0;
    while ((expPh.size() > 0 || expAcc.size() > 0) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    check(guard < 20000, "R11", "trace drained", guard, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL R11 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    // Program A, zero-latency memory: loads, adds, stores, jump over a word
    img = '{8'h4C, 8'h5D, 8'h01, 8'h8E, 8'h15, 8'h9F, 8'hC8, 8'h00,
            8'h00, 8'h8B, 8'hC0, 8'h00, 8'h23, 8'h41, 8'h00, 8'h00};
    varLat = 1'b0;
    runProgram(30);
    // Program B, rotating latency 1..3: jump to next word, reset-cleared registers
    img = '{8'hC1, 8'h6F, 8'h32, 8'h33, 8'hBE, 8'hAD, 8'h6E, 8'hC2,
            8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h07};
    varLat = 1'b1;
    runProgram(25);
    summary();
    $finish;
  end

endmodule